// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave-side protocol engine of a serial memory reached over SPI. Chip select, serial clock, data in and hold arrive as pins. They are brought into the system clock domain, and serial clock edges are found from the sampled values. The engine collects an opcode byte, then a 24-bit address where the command needs one, then data bytes. Read data comes from a storage read port and goes back on a data-out pin, which is driven only while it carries data.

Write-type commands are not executed here. The engine gathers them: write enable and disable, status write, array write, identification page write, and lock. When chip select rises it presents each complete command as a one-cycle pulse on a commit port, with the command kind, address, byte count and up to one page of data. The storage behind that port owns array timing, status bits and protection policy. It reports its status byte back, and bit 0 of that byte is the busy flag.

Top module: `spimem_front`

## Requirements
- R1: Serial clock modes (0,0) and (1,1) both work. Data in is taken on serial clock rising edges, data out changes on falling edges, and every byte travels MSB first.
- R2: miso_oe_o is low whenever chip select is high and in every phase that does not send data. It is high while read or status bytes are being sent.
- R3: After reset, nothing is decoded, committed or driven until chip select has been seen high at least once.
- R4: Opcodes: 0x06 commits kind 1 (enable), 0x04 kind 2 (disable), 0x01 kind 3 (status write), 0x02 kind 4 (array write), 0x82 kind 5 (identification write) or kind 6 (lock), 0x05 sends the status byte, 0x03 reads the array, 0x83 reads the identification page or the lock state.
- R5: A 24-bit address follows 0x03/0x02/0x82/0x83. For the array, bits 18..0 are kept. For 0x82/0x83, address bit 10 = 0 picks the identification page with bits 8..0 as the offset, and bit 10 = 1 picks lock. Lock and status commands report address 0. Read port space codes: 0 array, 1 identification page, 2 lock state.
- R6: An opcode outside the set makes the engine ignore the rest of the frame. Nothing is driven and nothing is committed.
- R7: A write-type command commits only if chip select rises after a whole number of bytes. Opcode-only commands need exactly 8 clocks. Commands with data need at least one complete data byte and no trailing partial bits.
- R8: Each commit is one cycle of cmd_valid_o, issued after chip select rises. cmd_data_o byte i sits in bits 8i+7..8i.
- R9: Hold starts when hold is low while the serial clock is low, and ends when hold is high while the clock is low. During hold, clock and data in are ignored and data out is released. Bit position is kept across the pause.
- R10: Raising chip select during hold ends the frame. A write that already has complete data bytes and no partial bits is still committed. A write with a partial byte is dropped.
- R11: Array reads auto-increment the address and wrap from 0x7FFFF to 0. Identification page reads wrap within the 9-bit offset.
- R12: At most PAGE data bytes are kept. cmd_len_o saturates at PAGE and later bytes are discarded.
- R13: While status bit 0 is 1, every opcode except 0x05 is refused as in R6. Status reads repeat the live status byte for as long as clocks continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data in pin |
| hold_n_i | input | 1 | Hold pin, active low |
| miso_o | output | 1 | Serial data out value |
| miso_oe_o | output | 1 | Output enable for the data-out pad |
| rd_space_o | output | 2 | Read space: 0 array, 1 identification page, 2 lock, 3 status |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | 8 | Read data for rd_space_o/rd_addr_o, valid in the same cycle |
| status_i | input | 8 | Status byte; bit 0 is busy |
| cmd_valid_o | output | 1 | One-cycle commit strobe |
| cmd_kind_o | output | 3 | Committed command kind (R4) |
| cmd_addr_o | output | ADDR_W | Committed address or offset |
| cmd_len_o | output | LEN_W | Number of data bytes kept |
| cmd_data_o | output | PAGE*8 | Data bytes, byte 0 in the low bits |

## Verification
The hardest case to reach is a frame that ends while hold is active. Hold must be entered with the clock low. Chip select must then rise at the same time, and the commit result depends on whether the last data byte was whole. The bench gets there with a bit-level driver that can stop inside a byte. It lowers hold with the clock idle and toggles clock and data in as noise during the pause. Then it either resumes or raises chip select. Both outcomes are checked: whole bytes commit, and partial bytes do not. Noise clocks during hold inside a read and inside a write must leave the byte unchanged.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_WIN, PH_ROUT, PH_DONE, PH_WAIT
  } phase_e;

  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRIT = 8'h02;
  localparam logic [7:0] OP_IDRD = 8'h83;
  localparam logic [7:0] OP_IDWR = 8'h82;

  localparam logic [2:0] K_NONE = 3'd0;
  localparam logic [2:0] K_WEN  = 3'd1;
  localparam logic [2:0] K_WDIS = 3'd2;
  localparam logic [2:0] K_STAT = 3'd3;
  localparam logic [2:0] K_ARR  = 3'd4;
  localparam logic [2:0] K_IDPG = 3'd5;
  localparam logic [2:0] K_LOCK = 3'd6;

  localparam logic [1:0] SP_ARR  = 2'd0;
  localparam logic [1:0] SP_IDPG = 2'd1;
  localparam logic [1:0] SP_LOCK = 2'd2;
  localparam logic [1:0] SP_STAT = 2'd3;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int             W   = 1,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      q      <= RST;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/spimem_pagebuf.sv
module spimem_pagebuf #(
  parameter int PAGE  = 16,
  parameter int LEN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [7:0]        din,
  output logic [LEN_W-1:0]  count,
  output logic [PAGE*8-1:0] flat
);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(PAGE);

  logic [LEN_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)                      cnt_n = '0;
    else if (we && cnt_q != FULL) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign count = cnt_q;

  for (genvar i = 0; i < PAGE; i++) begin : g_ent
    logic [7:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ent_q <= '0;
      else if (we && !clr && cnt_q == LEN_W'(i)) ent_q <= din;
    end
    assign flat[i*8 +: 8] = ent_q;
  end
endmodule

// File: rtl/spimem_txshift.sv
module spimem_txshift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       shift,
  input  logic [7:0] din,
  output logic       bit_o
);
  logic [7:0] sh_q, sh_n;

  always_comb begin
    sh_n = sh_q;
    if (load)       sh_n = din;
    else if (shift) sh_n = {sh_q[6:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign bit_o = sh_q[7];
endmodule

// File: rtl/spimem_front.sv
module spimem_front
  import spimem_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int ID_W    = 9,
  parameter int SEL_BIT = 10,
  parameter int PAGE    = 16,
  parameter int LEN_W   = $clog2(PAGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              hold_n_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [1:0]        rd_space_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic [7:0]        status_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_kind_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [PAGE*8-1:0] cmd_data_o
);
  localparam int HI_W = ADDR_W - 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_l = rst_sh_q[1];

  // pin sampling, order {hold, mosi, sck, cs}
  logic [3:0] pin_s;
  spimem_sync #(.W(4), .RST(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_l),
    .d({hold_n_i, mosi_i, sck_i, cs_n_i}), .q(pin_s)
  );
  logic cs_s, sck_s, mosi_s, hold_s;
  assign {hold_s, mosi_s, sck_s, cs_s} = pin_s;

  phase_e            phase_q, phase_n;
  logic [2:0]        cnt_q, cnt_n;
  logic [1:0]        abyte_q, abyte_n;
  logic [7:0]        op_q, op_n;
  logic [6:0]        sr_q, sr_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [1:0]        space_q, space_n;
  logic [2:0]        kind_q, kind_n;
  logic              cs_d_q, sck_d_q, primed_q, primed_n, hold_q, hold_n;

  logic              sel, rise, fall, cs_rise, commit;
  logic              buf_we, buf_clr, tx_load, tx_shift;
  logic [7:0]        byte_in, tx_din;
  logic [ADDR_W-1:0] full, idoff;
  logic              idsel;
  logic [LEN_W-1:0]  buf_cnt;
  logic [PAGE*8-1:0] buf_flat;

  assign sel      = primed_q & ~cs_s;
  assign rise     = sel & ~hold_q & sck_s & ~sck_d_q;
  assign fall     = sel & ~hold_q & ~sck_s & sck_d_q;
  assign cs_rise  = cs_s & ~cs_d_q;
  assign byte_in  = {sr_q, mosi_s};
  assign full     = {hi_q, byte_in};
  assign idsel    = full[SEL_BIT];
  assign idoff    = {{(ADDR_W-ID_W){1'b0}}, full[ID_W-1:0]};
  assign primed_n = primed_q | cs_s;
  assign tx_din   = (space_q == SP_STAT) ? status_i : rd_data_i;

  always_comb begin
    if (!sel)        hold_n = 1'b0;
    else if (!sck_s) hold_n = ~hold_s;
    else             hold_n = hold_q;
  end

  always_comb begin
    phase_n = phase_q;  cnt_n = cnt_q;     abyte_n = abyte_q;
    op_n    = op_q;     sr_n  = sr_q;      hi_n    = hi_q;
    addr_n  = addr_q;   space_n = space_q; kind_n  = kind_q;
    buf_we  = 1'b0;     buf_clr = 1'b0;    commit  = 1'b0;
    tx_load = 1'b0;     tx_shift = 1'b0;
    if (!sel) begin
      commit  = cs_rise && cnt_q == 3'd0 &&
                (phase_q == PH_DONE || (phase_q == PH_WIN && buf_cnt != '0));
      phase_n = PH_OPC;  cnt_n = '0;  abyte_n = '0;
      kind_n  = K_NONE;  addr_n = '0; buf_clr = 1'b1;
    end else if (rise) begin
      sr_n  = byte_in[6:0];
      cnt_n = cnt_q + 1'b1;
      if (phase_q == PH_DONE) begin
        phase_n = PH_WAIT;
      end else if (cnt_q == 3'd7) begin
        unique case (phase_q)
          PH_OPC: begin
            op_n = byte_in;
            if (status_i[0] && byte_in != OP_RDSR) phase_n = PH_WAIT;
            else begin
              case (byte_in)
                OP_WEN:  begin kind_n = K_WEN;  phase_n = PH_DONE; end
                OP_WDIS: begin kind_n = K_WDIS; phase_n = PH_DONE; end
                OP_RDSR: begin space_n = SP_STAT; phase_n = PH_ROUT; end
                OP_WRSR: begin kind_n = K_STAT; phase_n = PH_WIN; end
                OP_READ, OP_WRIT, OP_IDRD, OP_IDWR: phase_n = PH_ADDR;
                default: phase_n = PH_WAIT;
              endcase
            end
          end
          PH_ADDR: begin
            hi_n    = {hi_q[HI_W-9:0], byte_in};
            abyte_n = abyte_q + 1'b1;
            if (abyte_q == 2'd2) begin
              case (op_q)
                OP_READ: begin space_n = SP_ARR; addr_n = full; phase_n = PH_ROUT; end
                OP_WRIT: begin kind_n = K_ARR;   addr_n = full; phase_n = PH_WIN;  end
                OP_IDRD: begin
                  space_n = idsel ? SP_LOCK : SP_IDPG;
                  addr_n  = idsel ? '0 : idoff;
                  phase_n = PH_ROUT;
                end
                default: begin
                  kind_n  = idsel ? K_LOCK : K_IDPG;
                  addr_n  = idsel ? '0 : idoff;
                  phase_n = PH_WIN;
                end
              endcase
            end
          end
          PH_WIN:  buf_we = 1'b1;
          default: ;
        endcase
      end
    end else if (fall && phase_q == PH_ROUT) begin
      if (cnt_q == 3'd0) begin
        tx_load = 1'b1;
        if (space_q == SP_ARR)
          addr_n = addr_q + 1'b1;
        else if (space_q == SP_IDPG)
          addr_n = {{(ADDR_W-ID_W){1'b0}}, addr_q[ID_W-1:0] + 1'b1};
      end else begin
        tx_shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      phase_q <= PH_OPC; cnt_q <= '0;  abyte_q <= '0; op_q <= '0;
      sr_q <= '0;  hi_q <= '0;  addr_q <= '0; space_q <= SP_ARR;
      kind_q <= K_NONE; cs_d_q <= 1'b0; sck_d_q <= 1'b0;
      primed_q <= 1'b0; hold_q <= 1'b0;
    end else begin
      phase_q <= phase_n; cnt_q <= cnt_n; abyte_q <= abyte_n; op_q <= op_n;
      sr_q <= sr_n; hi_q <= hi_n; addr_q <= addr_n; space_q <= space_n;
      kind_q <= kind_n; cs_d_q <= cs_s; sck_d_q <= sck_s;
      primed_q <= primed_n; hold_q <= hold_n;
    end
  end

  spimem_pagebuf #(.PAGE(PAGE), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .rst_n(rst_l), .clr(buf_clr), .we(buf_we),
    .din(byte_in), .count(buf_cnt), .flat(buf_flat)
  );

  spimem_txshift u_tx (
    .clk(clk), .rst_n(rst_l), .load(tx_load), .shift(tx_shift),
    .din(tx_din), .bit_o(miso_o)
  );

  // commit port registers, loaded only on a commit
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      cmd_valid_o <= 1'b0; cmd_kind_o <= K_NONE; cmd_addr_o <= '0;
      cmd_len_o   <= '0;   cmd_data_o <= '0;
    end else begin
      cmd_valid_o <= commit;
      if (commit) begin
        cmd_kind_o <= kind_q;  cmd_addr_o <= addr_q;
        cmd_len_o  <= buf_cnt; cmd_data_o <= buf_flat;
      end
    end
  end

  assign miso_oe_o  = sel & ~hold_q & (phase_q == PH_ROUT);
  assign rd_space_o = space_q;
  assign rd_addr_o  = addr_q;
endmodule

// File: rtl/spimem_front_chk.sv
module spimem_front_chk #(
  parameter int PAGE  = 16,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n_i,
  input logic             sck_i,
  input logic             hold_n_i,
  input logic             miso_oe_o,
  input logic             cmd_valid_o,
  input logic [2:0]       cmd_kind_o,
  input logic [LEN_W-1:0] cmd_len_o
);
  logic [1:0] cshi_q;
  logic [1:0] hq_q;
  logic       seen_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cshi_q <= '0; hq_q <= '0; seen_hi_q <= 1'b0;
    end else begin
      if (!cs_n_i)           cshi_q <= '0;
      else if (cshi_q != 2'd3) cshi_q <= cshi_q + 1'b1;
      if (hold_n_i || sck_i || cs_n_i) hq_q <= '0;
      else if (hq_q != 2'd3)           hq_q <= hq_q + 1'b1;
      if (cs_n_i) seen_hi_q <= 1'b1;
    end
  end

  assert_quiet_deselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cshi_q >= 2'd2 |-> !miso_oe_o);
  assert_no_select_before_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_hi_q |-> (!cmd_valid_o && !miso_oe_o));
  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_kind_o >= 3'd1 && cmd_kind_o <= 3'd6));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  assert_commit_after_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cshi_q >= 2'd2);
  assert_hold_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hq_q == 2'd3 |-> !miso_oe_o);
  assert_len_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o >= 3'd3) |-> (cmd_len_o >= 1 && cmd_len_o <= LEN_W'(PAGE)));
endmodule

bind spimem_front spimem_front_chk #(.PAGE(PAGE), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sck_i(sck_i), .hold_n_i(hold_n_i),
  .miso_oe_o(miso_oe_o), .cmd_valid_o(cmd_valid_o), .cmd_kind_o(cmd_kind_o),
  .cmd_len_o(cmd_len_o)
);

// File: tb/spimem_front_test.sv
module spimem_front_test;
  localparam int AW = 19;
  localparam int PG = 16;
  localparam int LW = 5;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, hold_n;
  logic miso, miso_oe, cmd_valid;
  logic [1:0] rd_space;
  logic [AW-1:0] rd_addr, cmd_addr;
  logic [7:0] rd_data, stat;
  logic [2:0] cmd_kind;
  logic [LW-1:0] cmd_len;
  logic [PG*8-1:0] cmd_data;
  int checks = 0, fails = 0, ncmd = 0;
  logic [2:0] cap_kind;
  logic [AW-1:0] cap_addr;
  logic [LW-1:0] cap_len;
  logic [PG*8-1:0] cap_data;
  localparam logic [7:0] LOCKB = 8'h71;

  always #5 clk = ~clk;

  spimem_front uut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_n_i(hold_n), .miso_o(miso), .miso_oe_o(miso_oe), .rd_space_o(rd_space),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .status_i(stat),
    .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .cmd_addr_o(cmd_addr),
    .cmd_len_o(cmd_len), .cmd_data_o(cmd_data)
  );

  function automatic logic [7:0] arr_f(input logic [AW-1:0] a);
    return {a[18:16], a[4:0]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] id_f(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] dat_f(input int i);
    return 8'(i * 29 + 7);
  endfunction

  assign rd_data = (rd_space == 2'd0) ? arr_f(rd_addr) :
                   (rd_space == 2'd1) ? id_f(rd_addr) :
                   (rd_space == 2'd2) ? LOCKB : 8'h00;

  always @(posedge clk) begin
    if (cmd_valid) begin
      ncmd     <= ncmd + 1;
      cap_kind <= cmd_kind; cap_addr <= cmd_addr;
      cap_len  <= cmd_len;  cap_data <= cmd_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic r);
    sck = 1'b0; mosi = b; wait_clk(H);
    r = miso; sck = 1'b1; wait_clk(H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bitx(tx[i], rx[i]);
  endtask

  task automatic begin_frame(input logic idle);
    sck = idle; cs_n = 1'b0; wait_clk(8);
  endtask

  task automatic end_frame;
    sck = 1'b0; wait_clk(H); cs_n = 1'b1; wait_clk(14);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] rx;
    xfer(op, rx);
    xfer(a[23:16], rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  nd;
    logic [3:0]  extra;
    logic        busy;
    logic        ev;
    logic [2:0]  ek;
    logic [18:0] ea;
    logic [7:0]  el;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{8'h06, 24'h0, 8'd0, 4'd0, 1'b0, 1'b1, 3'd1, 19'h0, 8'd0},       // R4 enable
    '{8'h06, 24'h0, 8'd0, 4'd1, 1'b0, 1'b0, 3'd0, 19'h0, 8'd0},       // R7 extra bit
    '{8'h04, 24'h0, 8'd0, 4'd0, 1'b0, 1'b1, 3'd2, 19'h0, 8'd0},       // R4 disable
    '{8'h01, 24'h0, 8'd1, 4'd0, 1'b0, 1'b1, 3'd3, 19'h0, 8'd1},       // R4 status write
    '{8'h01, 24'h0, 8'd0, 4'd0, 1'b0, 1'b0, 3'd0, 19'h0, 8'd0},       // R7 no data
    '{8'h02, 24'h012345, 8'd2, 4'd0, 1'b0, 1'b1, 3'd4, 19'h12345, 8'd2}, // R5 array
    '{8'h02, 24'h012345, 8'd3, 4'd3, 1'b0, 1'b0, 3'd0, 19'h0, 8'd0},  // R7 partial
    '{8'h82, 24'h0001AB, 8'd1, 4'd0, 1'b0, 1'b1, 3'd5, 19'h1AB, 8'd1}, // R5 id page
    '{8'h82, 24'h000400, 8'd1, 4'd0, 1'b0, 1'b1, 3'd6, 19'h0, 8'd1},  // R5 lock
    '{8'h55, 24'h0, 8'd2, 4'd0, 1'b0, 1'b0, 3'd0, 19'h0, 8'd0},       // R6 invalid
    '{8'h02, 24'h000010, 8'd1, 4'd0, 1'b1, 1'b0, 3'd0, 19'h0, 8'd0},  // R13 busy
    '{8'h06, 24'h0, 8'd0, 4'd0, 1'b1, 1'b0, 3'd0, 19'h0, 8'd0},       // R13 busy
    '{8'h02, 24'h07FFF0, 8'd18, 4'd0, 1'b0, 1'b1, 3'd4, 19'h7FFF0, 8'd16}, // R12
    '{8'h02, 24'hF81234, 8'd1, 4'd0, 1'b0, 1'b1, 3'd4, 19'h01234, 8'd1}, // R5 upper
    '{8'h82, 24'hFFFA55, 8'd1, 4'd0, 1'b0, 1'b1, 3'd5, 19'h055, 8'd1}  // R5 bit10
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    logic r;
    int n0;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1; stat = 8'h02;
    wait_clk(5);
    check("R2 reset oe", 32'(miso_oe), 0);
    check("R8 reset valid", 32'(cmd_valid), 0);
    rst_n = 1'b1; wait_clk(5);
    // R3: chip select low since reset; an enable frame must be ignored
    n0 = ncmd;
    xfer(8'h06, rx);
    sck = 1'b0; wait_clk(H);
    check("R3 oe before first select", 32'(miso_oe), 0);
    cs_n = 1'b1; wait_clk(14);
    check("R3 no commit before first high", 32'(ncmd - n0), 0);

    foreach (VEC[v]) begin
      stat = VEC[v].busy ? 8'h03 : 8'h02;
      n0 = ncmd;
      begin_frame(1'b0);
      if (VEC[v].op inside {8'h02, 8'h03, 8'h82, 8'h83}) send_hdr(VEC[v].op, VEC[v].addr);
      else xfer(VEC[v].op, rx);
      for (int i = 0; i < int'(VEC[v].nd); i++) xfer(dat_f(i), rx);
      for (int i = 0; i < int'(VEC[v].extra); i++) bitx(1'b1, r);
      end_frame();
      check($sformatf("R7 vec%0d commit", v), 32'(ncmd - n0), 32'(VEC[v].ev));
      if (VEC[v].ev) begin
        check($sformatf("R4 vec%0d kind", v), 32'(cap_kind), 32'(VEC[v].ek));
        check($sformatf("R5 vec%0d addr", v), 32'(cap_addr), 32'(VEC[v].ea));
        check($sformatf("R12 vec%0d len", v), 32'(cap_len), 32'(VEC[v].el));
        if (VEC[v].el != 0) begin
          check($sformatf("R8 vec%0d byte0", v), 32'(cap_data[7:0]), 32'(dat_f(0)));
          check($sformatf("R8 vec%0d last", v), 32'(cap_data[(VEC[v].el-1)*8 +: 8]),
                32'(dat_f(int'(VEC[v].el) - 1)));
        end
      end
    end
    stat = 8'h02;

    // R11 array read with wrap
    begin_frame(1'b0);
    send_hdr(8'h03, 24'h07FFFE);
    xfer(8'h00, rx); check("R11 read 7FFFE", 32'(rx), 32'(arr_f(19'h7FFFE)));
    check("R2 oe while reading", 32'(miso_oe), 1);
    xfer(8'h00, rx); check("R11 read 7FFFF", 32'(rx), 32'(arr_f(19'h7FFFF)));
    xfer(8'h00, rx); check("R11 wrap to 0", 32'(rx), 32'(arr_f(19'h0)));
    end_frame();
    check("R2 oe after deselect", 32'(miso_oe), 0);

    // R11 identification page read wraps in 9 bits; R5 lock read
    begin_frame(1'b0);
    send_hdr(8'h83, 24'h0001FF);
    xfer(8'h00, rx); check("R11 id 1FF", 32'(rx), 32'(id_f(19'h1FF)));
    xfer(8'h00, rx); check("R11 id wrap", 32'(rx), 32'(id_f(19'h0)));
    end_frame();
    begin_frame(1'b0);
    send_hdr(8'h83, 24'h000400);
    xfer(8'h00, rx); check("R5 lock state read", 32'(rx), 32'(LOCKB));
    end_frame();

    // R13 status read repeats, also while busy
    stat = 8'h8C;
    begin_frame(1'b0);
    xfer(8'h05, rx);
    xfer(8'h00, rx); check("R13 status first", 32'(rx), 32'h8C);
    xfer(8'h00, rx); check("R13 status repeat", 32'(rx), 32'h8C);
    end_frame();
    stat = 8'h03;
    begin_frame(1'b0);
    xfer(8'h05, rx); xfer(8'h00, rx); check("R13 status while busy", 32'(rx), 32'h03);
    end_frame();
    begin_frame(1'b0);
    send_hdr(8'h03, 24'h000000);
    xfer(8'h00, rx); check("R13 read refused when busy", 32'(miso_oe), 0);
    end_frame();
    stat = 8'h02;

    // R6 invalid opcode then clocks: nothing driven
    begin_frame(1'b0);
    xfer(8'hA3, rx); xfer(8'h00, rx);
    check("R6 no drive after invalid", 32'(miso_oe), 0);
    end_frame();

    // R9 hold inside a write data byte
    n0 = ncmd;
    begin_frame(1'b0);
    send_hdr(8'h02, 24'h000010);
    for (int i = 7; i >= 4; i--) bitx(1'(8'hA7 >> i), r);
    sck = 1'b0; wait_clk(H); hold_n = 1'b0; wait_clk(H);
    for (int k = 0; k < 3; k++) begin
      mosi = 1'(k); sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
    end
    hold_n = 1'b1; wait_clk(H);
    for (int i = 3; i >= 0; i--) bitx(1'(8'hA7 >> i), r);
    end_frame();
    check("R9 write through hold commits", 32'(ncmd - n0), 1);
    check("R9 byte intact across hold", 32'(cap_data[7:0]), 32'hA7);

    // R9 hold inside a read byte
    begin_frame(1'b0);
    send_hdr(8'h03, 24'h000100);
    for (int i = 7; i >= 5; i--) bitx(1'b0, rx[i]);
    sck = 1'b0; wait_clk(H); hold_n = 1'b0; wait_clk(H);
    check("R9 output released in hold", 32'(miso_oe), 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
    end
    hold_n = 1'b1; wait_clk(H);
    for (int i = 4; i >= 0; i--) bitx(1'b0, rx[i]);
    check("R9 read byte across hold", 32'(rx), 32'(arr_f(19'h100)));
    end_frame();

    // R10 deselect in hold: whole byte commits, partial does not
    n0 = ncmd;
    begin_frame(1'b0);
    send_hdr(8'h02, 24'h000020);
    xfer(8'h3E, rx);
    sck = 1'b0; wait_clk(H); hold_n = 1'b0; wait_clk(H);
    cs_n = 1'b1; wait_clk(14); hold_n = 1'b1; wait_clk(4);
    check("R10 whole byte commits in hold", 32'(ncmd - n0), 1);
    check("R10 kind", 32'(cap_kind), 4);
    check("R10 data", 32'(cap_data[7:0]), 32'h3E);
    n0 = ncmd;
    begin_frame(1'b0);
    send_hdr(8'h02, 24'h000020);
    xfer(8'h3E, rx);
    for (int i = 0; i < 3; i++) bitx(1'b1, r);
    sck = 1'b0; wait_clk(H); hold_n = 1'b0; wait_clk(H);
    cs_n = 1'b1; wait_clk(14); hold_n = 1'b1; wait_clk(4);
    check("R10 partial byte dropped", 32'(ncmd - n0), 0);

    // R1 mode (1,1): clock idles high
    sck = 1'b1; wait_clk(4);
    begin_frame(1'b1);
    send_hdr(8'h03, 24'h000005);
    xfer(8'h00, rx); check("R1 mode 3 read", 32'(rx), 32'(arr_f(19'h5)));
    wait_clk(H); cs_n = 1'b1; wait_clk(14);
    n0 = ncmd;
    begin_frame(1'b1);
    xfer(8'h06, rx);
    wait_clk(H); cs_n = 1'b1; wait_clk(14);
    check("R1 mode 3 enable commit", 32'(ncmd - n0), 1);
    sck = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule